// File: doc/BRIEF.md
# Receive Byte FIFO with Level Interrupts

This block buffers bytes from a run-length producer until a processor collects them. The producer offers one byte per cycle on a push strobe and pulses a packet-end input when a burst is finished. The processor uses a simple word-wide register port with one cycle per access. Each read of the data address pops one byte.

Three interrupt sources are kept as sticky status bits: overflow, packet end, and data available. The data-available source compares the fill count against a programmable trigger level. Each source has its own enable bit. Writing ones to a status bit clears it. The status word also reports the current fill count, so one read tells the processor how many bytes to collect. The depth is a power-of-two parameter, and both 16 and 64 entries are supported.

Top module: `rx_level_fifo`

## Requirements
- R1: After reset the FIFO is empty, every status bit and enable bit is 0, the trigger level is 0, and `irq` is low.
- R2: Bytes come out in the order they were pushed. Each read at address 0 pops exactly one byte, which is returned in `reg_rdata[7:0]` during that read.
- R3: A read at address 0 while the FIFO is empty returns 0 and leaves the fill count unchanged.
- R4: A read at address 2 (status) returns the current fill count in bits [8 +: CW], where CW = log2(DEPTH)+1.
- R5: A push that arrives while the FIFO holds DEPTH bytes is dropped and sets status bit 0 (overflow). The stored bytes are not changed.
- R6: A pulse on `pkt_end` sets status bit 1 (packet end).
- R7: Status bit 4 (data available) is set one cycle after the fill count exceeds the trigger level, which is held in enable-register bits [8 +: CW]. The bit is set again after a clear if the condition still holds.
- R8: A write at address 2 clears each status bit whose data bit is 1 and leaves the others alone. Writing 0xFF clears all of them.
- R9: Address 1 holds the enables: bit 0 for overflow, bit 1 for packet end, bit 4 for data available. `irq` is high exactly when some status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Producer pushes `push_data` this cycle |
| push_data | input | 8 | Byte from the producer |
| pkt_end | input | 1 | Producer marks the end of a packet |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 0) |
| reg_addr | input | 2 | 0 data, 1 enables and level, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The in-RTL assertions check on every cycle that:
- the fill count never exceeds the depth;
- a push into a full FIFO raises overflow without moving the count;
- an empty read leaves the pointers alone;
- packet end and a count above the level always produce their flags;
- the interrupt stays low when nothing is enabled.

Only the bench scenarios can show the remaining behaviour:
- the byte ordering, and that the bytes held at overflow survive;
- the exact count field;
- the selective clearing of status bits by write-one-to-clear;
- a data-available flag that reasserts while the count still exceeds the level.

// File: rtl/rx_level_fifo.sv
module rx_level_fifo #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  input  logic [7:0]  push_data,
  input  logic        pkt_end,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, lvl;
  logic          en_ov, en_pe, en_av;
  logic          st_ov, st_pe, st_av;

  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire do_pop  = reg_rd && (reg_addr == 2'd0) && !empty;
  wire do_push = push_valid && !full;
  wire [7:0] clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata[7:0] : 8'h00;
  wire unused_wbits = ^{reg_wdata[31:8+CW], reg_wdata[7:5], reg_wdata[3:2]};

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en_ov, en_pe, en_av} <= '0;
      lvl <= '0;
    end else if (reg_wr && reg_addr == 2'd1) begin
      en_ov <= reg_wdata[0];
      en_pe <= reg_wdata[1];
      en_av <= reg_wdata[4];
      lvl   <= reg_wdata[8 +: CW];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {st_ov, st_pe, st_av} <= '0;
    end else begin
      st_ov <= (st_ov & ~clr[0]) | (push_valid & full);
      st_pe <= (st_pe & ~clr[1]) | pkt_end;
      st_av <= (st_av & ~clr[4]) | (cnt > lvl);
    end

  assign irq = (st_ov & en_ov) | (st_pe & en_pe) | (st_av & en_av);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[7:0] = empty ? 8'h00 : mem[rp];
      2'd1: begin
        reg_rdata[0] = en_ov;
        reg_rdata[1] = en_pe;
        reg_rdata[4] = en_av;
        reg_rdata[8 +: CW] = lvl;
      end
      2'd2: begin
        reg_rdata[0] = st_ov;
        reg_rdata[1] = st_pe;
        reg_rdata[4] = st_av;
        reg_rdata[8 +: CW] = cnt;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R5
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full) |=> st_ov);

  // R5
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && full && !(reg_rd && reg_addr == 2'd0)) |=> ($stable(cnt) && $stable(wp)));

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && empty && !push_valid) |=> (empty && $stable(rp)));

  // R6
  pkt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> st_pe);

  // R7
  avail_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > lvl) |=> st_av);

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_ov && !en_pe && !en_av) |-> !irq);
endmodule

// File: tb/rx_level_fifo_tb.sv
module rx_level_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 0, rst_n = 0;
  logic        push_valid = 0, pkt_end = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0]  push_data = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq;

  int total = 0, bad = 0;
  logic [7:0] exp_q [$];

  rx_level_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: every data-address read is compared with the scoreboard queue
  always @(negedge clk)
    if (rst_n && reg_rd && reg_addr == 2'd0) begin
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(reg_rdata == {24'h0, e}, "R2 pop order", reg_rdata, {24'h0, e});
      end else
        chk(reg_rdata == 32'h0, "R3 empty read", reg_rdata, 32'h0);
    end

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] b);
    push_valid = 1; push_data = b;
    tick();
    push_valid = 0;
    if (exp_q.size() < DEPTH) exp_q.push_back(b);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); v = reg_rdata;
    tick();
    reg_rd = 0;
  endtask

  task automatic chk_status(input string tag, input bit ov, input bit pe, input bit av);
    logic [31:0] v, e;
    tick(); tick();
    rd(2'd2, v);
    e = (32'(exp_q.size()) << 8) | (32'(av) << 4) | (32'(pe) << 1) | 32'(ov);
    chk(v == e, tag, v, e);
  endtask

  task automatic chk_irq(input string tag, input bit e);
    tick();
    chk(irq == e, tag, {31'h0, irq}, {31'h0, e});
  endtask

  task automatic drain;
    logic [31:0] v;
    while (exp_q.size() > 0) rd(2'd0, v);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    #(CLK_PERIOD * 3); rst_n = 1; tick();

    // R1 reset state
    chk_status("R1 reset status", 0, 0, 0);
    rd(2'd1, v); chk(v == 0, "R1 reset enables", v, 0);
    chk_irq("R1 reset irq", 0);

    // R2 R4 order and count, level 0 so avail sets
    push(8'hA1); push(8'h5C); push(8'h00);
    chk_status("R4 count three", 0, 0, 1);
    drain();
    rd(2'd0, v);  // R3 empty read
    wr(2'd2, 32'h10);
    chk_status("R3 count stays zero", 0, 0, 0);

    // R7 level 7, avail enabled
    wr(2'd1, (32'd7 << 8) | 32'h10);
    rd(2'd1, v); chk(v == ((32'd7 << 8) | 32'h10), "R9 enable readback", v, (32'd7 << 8) | 32'h10);
    for (int i = 0; i < 7; i++) push(8'(8'h30 + i));
    chk_status("R7 count equal level", 0, 0, 0);
    chk_irq("R9 irq low at level", 0);
    push(8'h37);
    chk_status("R7 count above level", 0, 0, 1);
    chk_irq("R9 irq from avail", 1);
    wr(2'd2, 32'h10);
    chk_status("R7 reassert after clear", 0, 0, 1);
    rd(2'd0, v); rd(2'd0, v);
    wr(2'd2, 32'h10);
    chk_status("R7 cleared below level", 0, 0, 0);
    chk_irq("R9 irq drops", 0);
    drain();

    // R5 overflow, enable overflow only, level 0
    wr(2'd1, 32'h01);
    for (int i = 0; i < DEPTH + 1; i++) push(8'(8'h80 + i));
    chk_status("R5 overflow flag and count", 1, 0, 1);
    chk_irq("R9 irq from overflow", 1);
    wr(2'd2, 32'h00);
    chk_status("R8 zero write no effect", 1, 0, 1);
    wr(2'd2, 32'h01);
    chk_status("R8 clear overflow only", 0, 0, 1);
    chk_irq("R9 avail masked", 0);
    drain();  // R5 stored bytes kept
    wr(2'd2, 32'hFF);
    chk_status("R8 clear all", 0, 0, 0);

    // R6 packet end
    wr(2'd1, 32'h00);
    pkt_end = 1; tick(); pkt_end = 0;
    chk_status("R6 packet end flag", 0, 1, 0);
    chk_irq("R9 pkt masked", 0);
    wr(2'd1, 32'h02);
    chk_irq("R9 pkt enabled", 1);
    for (int i = 0; i < DEPTH + 1; i++) push(8'(8'hC0 + i));
    wr(2'd2, 32'hFF);
    chk_status("R8 clear all while full", 0, 0, 1);
    chk_irq("R9 irq after clear all", 0);
    drain();
    wr(2'd2, 32'hFF);
    chk_status("R8 final clear", 0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule